// File: doc/BRIEF.md
# Load-Store Address Generator

This block forms the memory address for a word load or store from a 32-bit base value and a 12-bit unsigned offset magnitude. A direction bit sets whether the magnitude is added to the base or subtracted from it. A two-bit indexing mode selects one of three behaviours:

- **Offset mode** uses the sum as the access address and leaves the base untouched.
- **Pre-indexed mode** uses the sum both as the access address and as the new base.
- **Post-indexed mode** accesses at the original base and hands back the sum as the new base.

A request strobe starts the computation. One clock later the block presents these registered outputs:

- a valid flag;
- the address;
- a write-back enable;
- the value to write back into the base register.

A pipeline stage in front of the memory port uses the address. The register file takes the write-back pair. Stack-style sequences are built from a pre-indexed decrement followed later by a post-indexed increment.

Top module: `lsag_top`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `vld_o`, `wb_en_o`, `addr_o` and `wb_base_o` are all zero, even if `req_i` is high.
- R2: `vld_o` is high exactly one cycle after a cycle with `req_i` high, so back-to-back requests give back-to-back valid results.
- R3: The displacement is `+off_mag_i` when `off_sub_i` is 0 and `-off_mag_i` when it is 1, with `off_mag_i` a 12-bit unsigned magnitude (0 to 4095). Every displacement from -2048 to +2047 is therefore reachable.
- R4: Mode code 2'b00 (offset): `addr_o` = base + displacement, `wb_en_o` = 0, and `wb_base_o` = the original base.
- R5: Mode code 2'b01 (pre-indexed): `addr_o` = `wb_base_o` = base + displacement, and `wb_en_o` = 1.
- R6: Mode code 2'b10 (post-indexed): `addr_o` = the original base, `wb_base_o` = base + displacement, and `wb_en_o` = 1.
- R7: The unused mode code 2'b11 behaves exactly like offset mode, and write-back stays off.
- R8: Base plus displacement is computed modulo 2^32, and carries or borrows out of bit 31 are dropped silently.
- R9: A subtract with zero magnitude gives the same outputs as an add of zero.
- R10: In a cycle after one with `req_i` low, `vld_o` and `wb_en_o` are 0 and `addr_o` and `wb_base_o` keep their previous values.
- R11: A pre-indexed access with displacement -4 on base B, followed by a post-indexed access with +4 on the written-back base, accesses B-4 both times and returns B as the final write-back value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, one computation per high cycle |
| base_i | input | 32 | Base register value |
| off_mag_i | input | 12 | Unsigned offset magnitude |
| off_sub_i | input | 1 | 1 subtracts the magnitude, 0 adds it |
| mode_i | input | 2 | Indexing mode: 00 offset, 01 pre, 10 post, 11 treated as offset |
| vld_o | output | 1 | Result valid, one cycle after request |
| addr_o | output | 32 | Memory access address |
| wb_en_o | output | 1 | Base write-back enable |
| wb_base_o | output | 32 | Value to write into the base register |

## Verification
The properties assume that `base_i`, `off_mag_i`, `off_sub_i` and `mode_i` are known and steady at the clock edge where `req_i` is sampled high. The bench meets this by changing every input only on the falling edge, a half period before that edge. The hold properties assume nothing about inputs in idle cycles. The bench still changes the base between requests so that a design which copies inputs while idle would be exposed. Every mode code, including the spare one, is driven from the vector table along with wrap-around bases.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  typedef enum logic [1:0] {
    IDX_OFFSET = 2'b00,
    IDX_PRE    = 2'b01,
    IDX_POST   = 2'b10,
    IDX_SPARE  = 2'b11
  } idx_mode_e;
endpackage

// File: rtl/lsag_disp.sv
// Turns an unsigned magnitude and a direction bit into a signed displacement.
module lsag_disp #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic [OW-1:0] mag_i,
  input  logic          sub_i,
  output logic [AW-1:0] disp_o
);
  localparam int PADW = AW - OW;
  logic [AW-1:0] zext;
  always_comb begin
    zext   = {{PADW{1'b0}}, mag_i};
    disp_o = sub_i ? (~zext + {{(AW-1){1'b0}}, 1'b1}) : zext;
  end
endmodule

// File: rtl/lsag_adder.sv
// Modulo 2^AW sum of base and displacement.
module lsag_adder #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] sum_o
);
  always_comb sum_o = base_i + disp_i;
endmodule

// File: rtl/lsag_route.sv
// Chooses the access address and write-back behaviour for each mode.
module lsag_route #(
  parameter int AW = 32
) (
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] sum_i,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o
);
  import lsag_pkg::*;
  always_comb begin
    addr_o   = sum_i;
    wb_en_o  = 1'b0;
    wb_val_o = base_i;
    case (idx_mode_e'(mode_i))
      IDX_PRE: begin
        addr_o   = sum_i;
        wb_en_o  = 1'b1;
        wb_val_o = sum_i;
      end
      IDX_POST: begin
        addr_o   = base_i;
        wb_en_o  = 1'b1;
        wb_val_o = sum_i;
      end
      default: begin
        addr_o   = sum_i;
        wb_en_o  = 1'b0;
        wb_val_o = base_i;
      end
    endcase
  end
endmodule

// File: rtl/lsag_top.sv
module lsag_top #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_mag_i,
  input  logic          off_sub_i,
  input  logic [1:0]    mode_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_base_o
);
  logic [AW-1:0] disp;
  logic [AW-1:0] sum;
  logic [AW-1:0] addr_c;
  logic          wb_en_c;
  logic [AW-1:0] wb_val_c;

  lsag_disp #(.AW(AW), .OW(OW)) u_disp (
    .mag_i (off_mag_i),
    .sub_i (off_sub_i),
    .disp_o(disp)
  );

  lsag_adder #(.AW(AW)) u_add (
    .base_i(base_i),
    .disp_i(disp),
    .sum_o (sum)
  );

  lsag_route #(.AW(AW)) u_route (
    .mode_i  (mode_i),
    .base_i  (base_i),
    .sum_i   (sum),
    .addr_o  (addr_c),
    .wb_en_o (wb_en_c),
    .wb_val_o(wb_val_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o     <= 1'b0;
      wb_en_o   <= 1'b0;
      addr_o    <= '0;
      wb_base_o <= '0;
    end else begin
      vld_o   <= req_i;
      wb_en_o <= req_i & wb_en_c;
      if (req_i) begin
        addr_o    <= addr_c;
        wb_base_o <= wb_val_c;
      end
    end
  end
endmodule

// File: rtl/lsag_checker.sv
module lsag_checker #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          req_i,
  input logic [AW-1:0] base_i,
  input logic [OW-1:0] off_mag_i,
  input logic          off_sub_i,
  input logic [1:0]    mode_i,
  input logic          vld_o,
  input logic [AW-1:0] addr_o,
  input logic          wb_en_o,
  input logic [AW-1:0] wb_base_o
);
  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_i |=> vld_o);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!vld_o && !wb_en_o && $stable(addr_o) && $stable(wb_base_o)));
  p_offset_no_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 2'b00) |=> (!wb_en_o && wb_base_o == $past(base_i)));
  p_pre_same_r5: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 2'b01) |=> (wb_en_o && addr_o == wb_base_o));
  p_post_base_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 2'b10) |=> (wb_en_o && addr_o == $past(base_i)));
  p_spare_no_wb_r7: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 2'b11) |=> (!wb_en_o && wb_base_o == $past(base_i)));
  p_zero_mag_r9: assert property (@(posedge clk) disable iff (rst)
    (req_i && off_mag_i == '0) |=> (addr_o == $past(base_i) && wb_base_o == $past(base_i)));
  p_wb_implies_vld_r2: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> vld_o);
endmodule

bind lsag_top lsag_checker #(.AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .base_i(base_i),
  .off_mag_i(off_mag_i), .off_sub_i(off_sub_i), .mode_i(mode_i),
  .vld_o(vld_o), .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_base_o(wb_base_o)
);

// File: tb/sim_lsag_top.sv
`timescale 1ns/1ps
module sim_lsag_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [11:0] off_mag_i = '0;
  logic        off_sub_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        vld_o, wb_en_o;
  logic [31:0] addr_o, wb_base_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lsag_top u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .base_i(base_i),
    .off_mag_i(off_mag_i), .off_sub_i(off_sub_i), .mode_i(mode_i),
    .vld_o(vld_o), .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_base_o(wb_base_o)
  );

  localparam int NV = 10;
  // base, magnitude, subtract, mode, expected addr, expected wb value, expected wb enable
  localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h1000, 32'h2000, 32'h3000, 32'h3000,
                                          32'hFFFFFFF0, 32'h10, 32'h4000, 32'h5000, 32'h6000};
  localparam logic [11:0] V_MAG  [NV] = '{12'h8, 12'h8, 12'h10, 12'h7FF, 12'h800,
                                          12'h20, 12'h20, 12'h4, 12'h0, 12'hFFF};
  localparam logic        V_SUB  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [1:0]  V_MODE [NV] = '{2'b00, 2'b01, 2'b10, 2'b00, 2'b01,
                                          2'b01, 2'b10, 2'b11, 2'b01, 2'b00};
  localparam logic [31:0] V_ADDR [NV] = '{32'h1008, 32'h0FF8, 32'h2000, 32'h37FF, 32'h2800,
                                          32'h10, 32'h10, 32'h4004, 32'h5000, 32'h5001};
  localparam logic [31:0] V_WB   [NV] = '{32'h1000, 32'h0FF8, 32'h2010, 32'h3000, 32'h2800,
                                          32'h10, 32'hFFFFFFF0, 32'h4000, 32'h5000, 32'h6000};
  localparam logic        V_EN   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  // requirement per row: R4, R5, R6, R3 (+2047), R3 (-2048), R8 (carry), R8 (borrow), R7, R9, R3 (-4095)
  localparam int          V_REQ  [NV] = '{4, 5, 6, 3, 3, 8, 8, 7, 9, 3};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic [11:0] m, input logic s, input logic [1:0] md);
    @(negedge clk);
    req_i = 1'b1; base_i = b; off_mag_i = m; off_sub_i = s; mode_i = md;
    @(negedge clk);
    req_i = 1'b0; base_i = ~b;
  endtask

  task automatic expect_out(input string tag, input logic [31:0] a, input logic [31:0] w, input logic en);
    check(vld_o === 1'b1, {tag, " vld"}, {31'd0, vld_o}, 32'd1);
    check(addr_o === a, {tag, " addr"}, addr_o, a);
    check(wb_base_o === w, {tag, " wb_base"}, wb_base_o, w);
    check(wb_en_o === en, {tag, " wb_en"}, {31'd0, wb_en_o}, {31'd0, en});
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with a request pending
    req_i = 1'b1; base_i = 32'hABCD0000; off_mag_i = 12'h4; mode_i = 2'b01;
    repeat (3) @(negedge clk);
    check(vld_o === 1'b0 && wb_en_o === 1'b0, "R1 flags", {30'd0, vld_o, wb_en_o}, 32'd0);
    check(addr_o === 32'd0 && wb_base_o === 32'd0, "R1 data", addr_o | wb_base_o, 32'd0);
    req_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(vld_o === 1'b0 && addr_o === 32'd0, "R1 after release", addr_o, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(V_BASE[i], V_MAG[i], V_SUB[i], V_MODE[i]);
      expect_out($sformatf("R%0d row%0d", V_REQ[i], i), V_ADDR[i], V_WB[i], V_EN[i]);
    end

    // R10: idle cycle keeps data, drops flags
    @(negedge clk);
    check(vld_o === 1'b0 && wb_en_o === 1'b0, "R10 flags", {30'd0, vld_o, wb_en_o}, 32'd0);
    check(addr_o === 32'h5001, "R10 addr hold", addr_o, 32'h5001);
    check(wb_base_o === 32'h6000, "R10 wb hold", wb_base_o, 32'h6000);

    // R9: subtract zero equals add zero (post mode)
    drive(32'h7000, 12'h0, 1'b0, 2'b10);
    expect_out("R9 add0", 32'h7000, 32'h7000, 1'b1);
    drive(32'h7000, 12'h0, 1'b1, 2'b10);
    expect_out("R9 sub0", 32'h7000, 32'h7000, 1'b1);

    // R11: pre -4 then post +4 restores base
    drive(32'h8000, 12'h4, 1'b1, 2'b01);
    expect_out("R11 push", 32'h7FFC, 32'h7FFC, 1'b1);
    drive(32'h7FFC, 12'h4, 1'b0, 2'b10);
    expect_out("R11 pop", 32'h7FFC, 32'h8000, 1'b1);

    // R2: back-to-back requests
    @(negedge clk);
    req_i = 1'b1; base_i = 32'h100; off_mag_i = 12'h1; off_sub_i = 1'b0; mode_i = 2'b00;
    @(negedge clk);
    expect_out("R2 first", 32'h101, 32'h100, 1'b0);
    base_i = 32'h200; mode_i = 2'b01;
    @(negedge clk);
    req_i = 1'b0;
    expect_out("R2 second", 32'h201, 32'h201, 1'b1);
    @(negedge clk);
    check(vld_o === 1'b0, "R2 drop", {31'd0, vld_o}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule